// File: doc/BRIEF.md
# I2C SCL Minimum-Time and Hung-Bus Timer

This block paces the SCL line of an I2C controller. It is clocked by the system clock and counts machine-cycle ticks, where one tick stands for six CPU clocks. A 10-bit counter is reloaded at every SCL transition and at every start or stop condition. The reload value is eight minus a minimum-time count chosen by a 2-bit speed select. Because of this, the counter reaching eight means that the minimum SCL high or low time has passed. If the counter wraps past all ones, the bus is treated as hung.

The controller around it uses the minimum-time flag to time its own SCL edges and its start and stop conditions. The hung-bus flag and a one-cycle request to drop the slave enable and the master request let the controller recover. The block also provides an SDA gate. Outgoing data may drive SDA only while the gate is high, which is only while SCL is low. Because of this gate, software that writes data early can never change SDA during an SCL high phase.

Top module: `i2c_scl_pacer`

## Requirements
- R1: The speed select `speed_sel` sets the minimum-time count: 2'b10 gives 7 ticks, 2'b01 gives 6, 2'b00 gives 5 and 2'b11 gives 4. After a reload, `min_done` is first read high once exactly that many `mc_tick` cycles have been counted.
- R2: A level change on `scl_in`, a `start_det` pulse or a `stop_det` pulse reloads the counter and clears `min_done`. A reload takes priority over a tick in the same cycle, so that tick is not counted.
- R3: With `run_en` at 1 and a frame open, the hung-bus timeout fires 1023, 1022, 1021 or 1020 ticks after the reload, for selects 10, 01, 00 and 11 respectively. A frame is open from a `start_det` pulse until a `stop_det` pulse.
- R4: When `slave_en`, `master_req` and `is_master` are all 0, the counter is cleared and held, `min_done` stays 0 and ticks have no effect.
- R5: With any enable at 1 and `run_en` at 0, only the low 3 counter bits run. `min_done` still works, and no timeout ever occurs.
- R6: With `run_en` at 1 but no frame open, the counter paces the minimum time only, and no timeout occurs.
- R7: `tmo_flag` is set on the tick on which the counter wraps from all ones. It stays set until `ovf_clr` or reset clears it. If a wrap and `ovf_clr` occur in the same cycle, the set wins.
- R8: `drop_enables` is a one-cycle pulse. It is raised in the same cycle in which `tmo_flag` is set.
- R9: `sda_gate` is high only while the interface is enabled (any enable at 1) and `scl_in` is low.
- R10: After reset, `min_done`, `tmo_flag` and `drop_enables` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | One-cycle machine-cycle tick |
| scl_in | input | 1 | Observed SCL level, already synchronous |
| start_det | input | 1 | Start condition detected strobe |
| stop_det | input | 1 | Stop condition detected strobe |
| slave_en | input | 1 | Slave functions enabled |
| master_req | input | 1 | Bus mastership requested |
| is_master | input | 1 | Currently bus master |
| run_en | input | 1 | Full 10-bit counter and hung-bus check enabled |
| speed_sel | input | 2 | Minimum-time count select |
| ovf_clr | input | 1 | Write-one clear of the timeout flag |
| min_done | output | 1 | Minimum SCL high/low time has elapsed |
| tmo_flag | output | 1 | Sticky hung-bus timeout flag |
| drop_enables | output | 1 | Pulse requesting clear of slave enable and master request |
| sda_gate | output | 1 | Outgoing data may drive SDA |

## Verification
On every cycle, the assertions check the following:
- Reloads load the preload value selected by `speed_sel`.
- The counter stays still when there is no tick.
- The upper bits are cleared whenever `run_en` is low.
- A disabled interface holds everything at zero.
- The timeout flag is sticky.
- The drop request is a single pulse that coincides with the flag being set, and it only follows a cycle with `run_en` high and a frame open.

Only the bench scenarios can show the following:
- The exact tick counts for each speed select, both for the minimum time and for the timeout.
- That a reload beats a tick in the same cycle.
- That no timeout occurs outside a frame or in low-bits mode.
- That a set beats a clear in the same cycle.

// File: rtl/i2c_tmr_pkg.sv
`timescale 1ns/1ps
package i2c_tmr_pkg;

    localparam int TMR_CNT_W = 10;
    localparam int TMR_LOW_W = 3;

    // Minimum SCL high/low time in machine cycles for each speed select.
    function automatic logic [3:0] min_cycles(input logic [1:0] sel);
        logic [3:0] n;
        case (sel)
            2'b10:   n = 4'd7;
            2'b01:   n = 4'd6;
            2'b00:   n = 4'd5;
            default: n = 4'd4;
        endcase
        return n;
    endfunction

    typedef struct packed {
        logic scl;
        logic busy;
    } sense_state_t;

    typedef struct packed {
        logic [TMR_CNT_W-1:0] cnt;
        logic                 min_done;
    } cnt_state_t;

    typedef struct packed {
        logic tmo;
        logic drop;
    } flag_state_t;

endpackage

// File: rtl/i2c_tmr_sense.sv
`timescale 1ns/1ps
module i2c_tmr_sense
    import i2c_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic start_det,
    input  logic stop_det,
    output logic reload,
    output logic in_frame
);

    sense_state_t st_d, st_q;
    logic         scl_edge;

    always_comb begin
        st_d     = st_q;
        st_d.scl = scl_in;
        if (start_det) begin
            st_d.busy = 1'b1;
        end else if (stop_det) begin
            st_d.busy = 1'b0;
        end
        scl_edge = scl_in ^ st_q.scl;
        reload   = scl_edge | start_det | stop_det;
        in_frame = st_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl: 1'b1, busy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_FRAME_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> in_frame); // R3

endmodule

// File: rtl/i2c_tmr_count.sv
`timescale 1ns/1ps
module i2c_tmr_count
    import i2c_tmr_pkg::*;
#(
    parameter int CNT_W = TMR_CNT_W,
    parameter int LOW_W = TMR_LOW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enabled,
    input  logic             run_en,
    input  logic             in_frame,
    input  logic             reload,
    input  logic [1:0]       sel,
    output logic             min_done,
    output logic             wrap
);

    localparam int MARK = 1 << LOW_W;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] pre;
    logic             full_run;
    logic             low_carry;

    always_comb begin
        pre       = CNT_W'(MARK) - CNT_W'(min_cycles(sel));
        full_run  = run_en & in_frame;
        low_carry = tick & (&st_q.cnt[LOW_W-1:0]);
        st_d      = st_q;
        wrap      = 1'b0;
        if (!enabled) begin
            st_d.cnt      = '0;
            st_d.min_done = 1'b0;
        end else if (reload) begin
            st_d.cnt      = pre;
            st_d.min_done = 1'b0;
        end else begin
            if (!run_en) begin
                st_d.cnt[CNT_W-1:LOW_W] = '0;
            end
            if (tick) begin
                if (full_run) begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                    wrap     = &st_q.cnt;
                end else begin
                    st_d.cnt[LOW_W-1:0] = st_q.cnt[LOW_W-1:0] + LOW_W'(1);
                end
            end
            if (low_carry) begin
                st_d.min_done = 1'b1;
            end
        end
        min_done = st_q.min_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PRELOAD_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && reload) |=> (st_q.cnt == $past(pre) && !min_done)); // R2
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && !reload && !tick && run_en) |=> $stable(st_q.cnt)); // R2
    AST_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && !run_en) |=> (st_q.cnt[CNT_W-1:LOW_W] == '0)); // R5
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> (st_q.cnt == '0 && !min_done)); // R4

endmodule

// File: rtl/i2c_tmr_flags.sv
`timescale 1ns/1ps
module i2c_tmr_flags
    import i2c_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic ovf_clr,
    output logic tmo_flag,
    output logic drop_en
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.drop = wrap;
        if (wrap) begin
            st_d.tmo = 1'b1;
        end else if (ovf_clr) begin
            st_d.tmo = 1'b0;
        end
        tmo_flag = st_q.tmo;
        drop_en  = st_q.drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !ovf_clr) |=> tmo_flag); // R7
    AST_TMO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !wrap) |=> !tmo_flag); // R7
    AST_DROP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        drop_en |=> !drop_en); // R8
    AST_TMO_RISE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> drop_en); // R8

endmodule

// File: rtl/i2c_scl_pacer.sv
`timescale 1ns/1ps
module i2c_scl_pacer
    import i2c_tmr_pkg::*;
#(
    parameter int CNT_W = TMR_CNT_W,
    parameter int LOW_W = TMR_LOW_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mc_tick,
    input  logic       scl_in,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       slave_en,
    input  logic       master_req,
    input  logic       is_master,
    input  logic       run_en,
    input  logic [1:0] speed_sel,
    input  logic       ovf_clr,
    output logic       min_done,
    output logic       tmo_flag,
    output logic       drop_enables,
    output logic       sda_gate
);

    logic enabled;
    logic reload;
    logic in_frame;
    logic wrap;

    always_comb begin
        enabled  = slave_en | master_req | is_master;
        sda_gate = enabled & ~scl_in;
    end

    i2c_tmr_sense u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .start_det (start_det),
        .stop_det  (stop_det),
        .reload    (reload),
        .in_frame  (in_frame)
    );

    i2c_tmr_count #(
        .CNT_W (CNT_W),
        .LOW_W (LOW_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (mc_tick),
        .enabled  (enabled),
        .run_en   (run_en),
        .in_frame (in_frame),
        .reload   (reload),
        .sel      (speed_sel),
        .min_done (min_done),
        .wrap     (wrap)
    );

    i2c_tmr_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .ovf_clr  (ovf_clr),
        .tmo_flag (tmo_flag),
        .drop_en  (drop_enables)
    );

    AST_DROP_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        drop_enables |-> $past(run_en && in_frame && enabled)); // R3

endmodule

// File: tb/i2c_scl_pacer_bench.sv
`timescale 1ns/1ps
module i2c_scl_pacer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       scl_in = 1'b1;
    logic       start_det = 1'b0;
    logic       stop_det = 1'b0;
    logic       slave_en = 1'b0;
    logic       master_req = 1'b0;
    logic       is_master = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] speed_sel = 2'b00;
    logic       ovf_clr = 1'b0;
    logic       min_done, tmo_flag, drop_enables, sda_gate;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    i2c_scl_pacer u_i2c_scl_pacer (
        .clk          (clk),
        .rst_n        (rst_n),
        .mc_tick      (mc_tick),
        .scl_in       (scl_in),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .slave_en     (slave_en),
        .master_req   (master_req),
        .is_master    (is_master),
        .run_en       (run_en),
        .speed_sel    (speed_sel),
        .ovf_clr      (ovf_clr),
        .min_done     (min_done),
        .tmo_flag     (tmo_flag),
        .drop_enables (drop_enables),
        .sda_gate     (sda_gate)
    );

    typedef struct packed {
        logic [1:0] sel;
        int         min_t;
        int         tmo_t;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{sel: 2'b10, min_t: 7, tmo_t: 1023},
        '{sel: 2'b01, min_t: 6, tmo_t: 1022},
        '{sel: 2'b00, min_t: 5, tmo_t: 1021},
        '{sel: 2'b11, min_t: 4, tmo_t: 1020}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_det = 1'b1; step(); start_det = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_det = 1'b1; step(); stop_det = 1'b0;
    endtask

    task automatic toggle_scl();
        scl_in = ~scl_in; step();
    endtask

    // Ticks every cycle until min_done is read high; returns the count.
    task automatic count_min(output int n);
        n = 0;
        mc_tick = 1'b1;
        while (!min_done && n < 20) begin
            step(); n++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int total;
        int seen;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10: reset state
        chk(min_done == 1'b0 && tmo_flag == 1'b0 && drop_enables == 1'b0, "R10",
            {min_done, tmo_flag, drop_enables}, 0);

        // R1 R3 R7 R8: table walk over the speed selects
        foreach (VECS[i]) begin
            slave_en = 1'b1; run_en = 1'b1; speed_sel = VECS[i].sel;
            mc_tick = 1'b0;
            pulse_start();
            toggle_scl();
            count_min(n);
            chk(n == VECS[i].min_t, "R1", n, VECS[i].min_t);
            total = n;
            while (!drop_enables && total < 1100) begin
                step(); total++;
            end
            chk(total == VECS[i].tmo_t, "R3", total, VECS[i].tmo_t);
            chk(tmo_flag == 1'b1, "R7", tmo_flag, 1);
            step();
            chk(drop_enables == 1'b0 && tmo_flag == 1'b1, "R8",
                {drop_enables, tmo_flag}, 1);
            mc_tick = 1'b0;
            ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
            chk(tmo_flag == 1'b0, "R7", tmo_flag, 0);
            pulse_stop();
            toggle_scl();
        end

        // R4: disabled, ticks have no effect
        slave_en = 1'b0; run_en = 1'b1; master_req = 1'b0; is_master = 1'b0;
        scl_in = 1'b0; step();
        seen = 0;
        mc_tick = 1'b1;
        for (int k = 0; k < 30; k++) begin
            step();
            if (min_done) seen = 1;
        end
        chk(seen == 0, "R4", seen, 0);
        // R9: gate low while disabled even with SCL low
        chk(sda_gate == 1'b0, "R9", sda_gate, 0);
        mc_tick = 1'b0;

        // R9: gate follows SCL low when enabled
        is_master = 1'b1; #1;
        chk(sda_gate == 1'b1, "R9", sda_gate, 1);
        scl_in = 1'b1; #1;
        chk(sda_gate == 1'b0, "R9", sda_gate, 0);
        step();
        is_master = 1'b0;

        // R5: low-bits only, no timeout
        slave_en = 1'b1; run_en = 1'b0; speed_sel = 2'b01;
        pulse_start();
        toggle_scl();
        count_min(n);
        chk(n == 6, "R5", n, 6);
        seen = 0;
        for (int k = 0; k < 1100; k++) begin
            step();
            if (drop_enables || tmo_flag) seen = 1;
        end
        chk(seen == 0, "R5", seen, 0);
        mc_tick = 1'b0;

        // R2: stop reloads and clears min_done
        pulse_stop();
        chk(min_done == 1'b0, "R2", min_done, 0);

        // R6: run enabled but no frame open
        run_en = 1'b1; speed_sel = 2'b00;
        toggle_scl();
        count_min(n);
        chk(n == 5, "R6", n, 5);
        seen = 0;
        for (int k = 0; k < 1100; k++) begin
            step();
            if (drop_enables || tmo_flag) seen = 1;
        end
        chk(seen == 0, "R6", seen, 0);
        mc_tick = 1'b0;

        // R4: disabling clears min_done
        slave_en = 1'b0; step();
        chk(min_done == 1'b0, "R4", min_done, 0);

        // R2: reload beats tick in the same cycle
        slave_en = 1'b1; speed_sel = 2'b10;
        pulse_start();
        toggle_scl();
        mc_tick = 1'b1;
        repeat (3) step();
        scl_in = ~scl_in; step();
        chk(min_done == 1'b0, "R2", min_done, 0);
        count_min(n);
        chk(n == 7, "R2", n, 7);
        mc_tick = 1'b0;

        // R7: wrap and clear in the same cycle, set wins
        speed_sel = 2'b11;
        toggle_scl();
        mc_tick = 1'b1;
        repeat (1019) step();
        chk(tmo_flag == 1'b0, "R7", tmo_flag, 0);
        ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
        chk(tmo_flag == 1'b1 && drop_enables == 1'b1, "R7",
            {tmo_flag, drop_enables}, 3);
        mc_tick = 1'b0;
        step();
        chk(tmo_flag == 1'b1, "R7", tmo_flag, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule